// File: doc/BRIEF.md
# Bandwidth-Stealing Packet Switch Allocator

This block allocates the output channels of a hybrid router to buffered packet flits. The output side has a number of physical circuit channels. Each circuit channel normally carries circuit flits, which go straight through with no arbitration. Each waiting packet flit names the circuit channel it has been given. It may borrow that channel in any cycle when no circuit flit is arriving for it. A packet flit that wins crosses the switch one cycle after its grant, with its circuit field left at zero. The next router therefore buffers it as a packet flit.

A circuit flit can arrive on a channel while a packet flit granted one cycle earlier is still crossing that channel. The block then holds the circuit flit in a one-entry holding register for that channel and sends it one cycle later. Packet flits that contend for the same channel in the same cycle are served in round-robin order. A packet flit can wait too long because its channel is kept busy by circuit traffic. In that case the block issues a reclaim request for the circuit channel that has gone longest without circuit traffic, so that this channel can be handed over to packet use.

Top module: `psa_steal_alloc`

## Requirements
- R1: A circuit flit that arrives on an idle channel appears on that channel's output after the next clock edge, with the circuit field set to 1 and its data unchanged.
- R2: No packet flit is granted in a cycle in which a circuit flit is arriving on the channel that flit is assigned to.
- R3: A packet flit granted in cycle t appears on its channel's output after the edge that ends cycle t+1, with the circuit field at 0 and its data unchanged.
- R4: A circuit flit that arrives while a packet flit is crossing the same channel is held. It appears one edge later than it would on an idle channel, with the circuit field set to 1.
- R5: A channel grants at most one packet flit per cycle. Among contenders for a channel, the lowest port index has priority after reset. After each grant, priority moves to the port one index above the winner, wrapping around.
- R6: A port that has requested for TIMEOUT consecutive cycles without a grant causes a one-cycle reclaim pulse on the following edge. The port's wait count restarts from zero when the port is granted, when it drops its request, or when its reclaim fires.
- R7: The reclaim request names the channel with the most cycles since its last circuit flit arrival. A tie goes to the lowest channel index.
- R8: After reset, all channel outputs are invalid, all grants are low and no reclaim request is raised.
- R9: Packet flits assigned to different channels are granted in the same cycle, independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_valid | input | NCIRC | Circuit flit arriving on each channel this cycle |
| cs_data | input | NCIRC*DW | Payload of each arriving circuit flit |
| pk_req | input | NPORT | Head packet flit present at each input port |
| pk_circ | input | NPORT*CW | Channel assigned to each port's head packet flit |
| pk_data | input | NPORT*DW | Payload of each port's head packet flit |
| pk_gnt | output | NPORT | Port's packet flit wins its channel this cycle (combinational) |
| out_valid | output | NCIRC | Flit leaving on each channel |
| out_cfield | output | NCIRC | Circuit field of the leaving flit: 1 for circuit, 0 for packet |
| out_data | output | NCIRC*DW | Payload of the leaving flit |
| reclaim_valid | output | 1 | One-cycle request to hand a channel over to packet use |
| reclaim_circ | output | CW | Channel named by the reclaim request |

## Verification
The assertions assume that the channel numbers on pk_circ are below NCIRC whenever pk_req is high. They also assume that a port keeps its flit and request stable until it is granted. The checks that a held flit is always sent rely on the upstream router never sending circuit flits into a channel faster than one per cycle. That limit holds because each channel input is a single-bit valid. The directed tasks only ever use legal channel numbers. They change a port's request only after that port has been granted or at the end of a scenario.

// File: rtl/psa_pkg.sv
// Shared definitions for the bandwidth-stealing packet allocator.
// Assumes nothing beyond a SystemVerilog 2017 compiler.
package psa_pkg;

    // Which source drives a channel's output register on a given edge.
    typedef enum logic [1:0] {
        SRC_IDLE = 2'd0,
        SRC_PKT  = 2'd1,
        SRC_HELD = 2'd2,
        SRC_CIRC = 2'd3
    } psa_src_e;

endpackage

// File: rtl/psa_rr_arb.sv
// Round-robin arbiter for one circuit channel.
// Grants at most one requester per cycle, combinationally. The priority
// pointer moves to the port just above the winner after each grant.
// Assumes N >= 2.
module psa_rr_arb #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    localparam int IW = $clog2(N);

    logic [IW-1:0] ptr;
    logic [IW-1:0] win;
    logic          found;

    // Search from the pointer upward (wrapping) for the first requester.
    always_comb begin
        gnt   = '0;
        win   = '0;
        found = 1'b0;
        for (int i = 0; i < N; i++) begin
            int idx;
            idx = (int'(ptr) + i) % N;
            if (!found && req[idx]) begin
                gnt[idx] = 1'b1;
                win      = IW'(idx);
                found    = 1'b1;
            end
        end
    end

    // Advance priority past the winner.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (found) begin
            ptr <= IW'((int'(win) + 1) % N);
        end
    end

    AST_ARB_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));                                            // R5
    AST_ARB_FAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (found && req[win] && $countones(req) > 1) |=> !gnt[$past(win)] || !$past(found) || $countones($past(req)) < 2 || !req[$past(win)] || $countones(req) == 1); // R5

endmodule

// File: rtl/psa_chan.sv
// Output stage of one circuit channel.
// A granted packet flit crosses the switch one cycle after its grant. A
// circuit flit goes straight to the output register unless a packet flit
// is crossing, or a held flit is leaving, in which case it waits one
// cycle in a single-entry holding register.
// Assumes the allocator never grants a packet in a cycle with a circuit
// flit arriving on this channel.
module psa_chan #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_valid,
    input  logic [DW-1:0] cs_data,
    input  logic          ps_grant,
    input  logic [DW-1:0] ps_data,
    output logic          out_valid,
    output logic          out_cfield,
    output logic [DW-1:0] out_data
);
    import psa_pkg::*;

    logic          ps_valid;
    logic [DW-1:0] ps_d;
    logic          held_valid;
    logic [DW-1:0] held_d;
    psa_src_e      src;

    // Choose what leaves on the next edge: crossing packet, held flit, new circuit flit.
    always_comb begin
        if (ps_valid)        src = SRC_PKT;
        else if (held_valid) src = SRC_HELD;
        else if (cs_valid)   src = SRC_CIRC;
        else                 src = SRC_IDLE;
    end

    // Register the switch traversal stage, holding register and output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ps_valid   <= 1'b0;
            ps_d       <= '0;
            held_valid <= 1'b0;
            held_d     <= '0;
            out_valid  <= 1'b0;
            out_cfield <= 1'b0;
            out_data   <= '0;
        end else begin
            ps_valid   <= ps_grant;
            ps_d       <= ps_data;
            held_valid <= (src == SRC_PKT || src == SRC_HELD) && cs_valid;
            held_d     <= cs_data;
            out_valid  <= (src != SRC_IDLE);
            out_cfield <= (src == SRC_HELD || src == SRC_CIRC);
            unique case (src)
                SRC_PKT:  out_data <= ps_d;
                SRC_HELD: out_data <= held_d;
                SRC_CIRC: out_data <= cs_data;
                default:  out_data <= '0;
            endcase
        end
    end

    AST_CS_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_valid && !ps_valid && !held_valid) |=> (out_valid && out_cfield && out_data == $past(cs_data))); // R1
    AST_PKT_ZERO_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        ps_valid |=> (out_valid && !out_cfield));                  // R3
    AST_COLLIDE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ps_valid && cs_valid) |=> held_valid);                    // R4
    AST_HELD_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        held_valid |=> (out_valid && out_cfield));                 // R4
    AST_HOLD_PKT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(held_valid && ps_valid));                                // R4

endmodule

// File: rtl/psa_starve.sv
// Starvation watch and least-recently-used channel tracking.
// Counts consecutive ungranted request cycles for each port. When a port
// reaches TIMEOUT, a one-cycle reclaim pulse names the channel with the
// longest time since its last circuit flit. Ties go to the lowest index.
// Only one port fires per edge (lowest index); the others stay at TIMEOUT.
// Assumes NCIRC >= 2 and TIMEOUT >= 1.
module psa_starve #(
    parameter int NPORT   = 4,
    parameter int NCIRC   = 4,
    parameter int TIMEOUT = 16,
    parameter int AGE_W   = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NPORT-1:0]         pk_req,
    input  logic [NPORT-1:0]         pk_gnt,
    input  logic [NCIRC-1:0]         cs_valid,
    output logic                     reclaim_valid,
    output logic [$clog2(NCIRC)-1:0] reclaim_circ
);
    localparam int CW   = $clog2(NCIRC);
    localparam int TW   = $clog2(TIMEOUT + 1);
    localparam int PW   = (NPORT > 1) ? $clog2(NPORT) : 1;
    localparam logic [TW-1:0]    TLIM    = TW'(TIMEOUT);
    localparam logic [AGE_W-1:0] AGE_MAX = '1;

    logic [TW-1:0]    cnt [NPORT];
    logic [AGE_W-1:0] age [NCIRC];
    logic             fire;
    logic [PW-1:0]    fire_port;
    logic [CW-1:0]    lru;

    // Pick the lowest-index port whose wait has reached the limit.
    always_comb begin
        fire      = 1'b0;
        fire_port = '0;
        for (int p = NPORT - 1; p >= 0; p--) begin
            if (cnt[p] == TLIM) begin
                fire      = 1'b1;
                fire_port = PW'(p);
            end
        end
    end

    // Pick the channel idle longest; strict compare keeps the lowest index on ties.
    always_comb begin
        lru = '0;
        for (int c = 1; c < NCIRC; c++) begin
            if (age[c] > age[lru]) lru = CW'(c);
        end
    end

    // Per-port consecutive wait counters.
    generate
        for (genvar p = 0; p < NPORT; p++) begin : g_wait
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cnt[p] <= '0;
                end else if (fire && fire_port == PW'(p)) begin
                    cnt[p] <= '0;
                end else if (!pk_req[p] || pk_gnt[p]) begin
                    cnt[p] <= '0;
                end else if (cnt[p] != TLIM) begin
                    cnt[p] <= cnt[p] + 1'b1;
                end
            end
            AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
                cnt[p] <= TLIM);                                   // R6
            AST_WAIT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
                pk_gnt[p] |=> cnt[p] == '0);                       // R6
        end

        // Per-channel saturating age since last circuit flit arrival.
        for (genvar c = 0; c < NCIRC; c++) begin : g_age
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    age[c] <= '0;
                end else if (cs_valid[c]) begin
                    age[c] <= '0;
                end else if (age[c] != AGE_MAX) begin
                    age[c] <= age[c] + 1'b1;
                end
            end
        end
    endgenerate

    // Register the reclaim request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reclaim_valid <= 1'b0;
            reclaim_circ  <= '0;
        end else begin
            reclaim_valid <= fire;
            if (fire) reclaim_circ <= lru;
        end
    end

    AST_RECLAIM_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (reclaim_valid && $past(cs_valid != '1)) |-> !$past(cs_valid[reclaim_circ])); // R7

endmodule

// File: rtl/psa_steal_alloc.sv
// Packet switch allocator that borrows idle circuit channels.
// Each port offers one head packet flit tagged with its assigned channel.
// A port may compete only when no circuit flit arrives on that channel
// this cycle; contenders per channel are served round-robin. Grants are
// combinational; granted data crosses one cycle later. Long waits raise a
// reclaim request for the least recently used channel.
// Assumes pk_circ < NCIRC while pk_req is high.
module psa_steal_alloc #(
    parameter  int NPORT   = 4,
    parameter  int NCIRC   = 4,
    parameter  int DW      = 16,
    parameter  int TIMEOUT = 16,
    parameter  int AGE_W   = 6,
    localparam int CW      = $clog2(NCIRC)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NCIRC-1:0]      cs_valid,
    input  logic [NCIRC*DW-1:0]   cs_data,
    input  logic [NPORT-1:0]      pk_req,
    input  logic [NPORT*CW-1:0]   pk_circ,
    input  logic [NPORT*DW-1:0]   pk_data,
    output logic [NPORT-1:0]      pk_gnt,
    output logic [NCIRC-1:0]      out_valid,
    output logic [NCIRC-1:0]      out_cfield,
    output logic [NCIRC*DW-1:0]   out_data,
    output logic                  reclaim_valid,
    output logic [CW-1:0]         reclaim_circ
);
    logic [NPORT-1:0] creq [NCIRC];
    logic [NPORT-1:0] cgnt [NCIRC];
    logic [DW-1:0]    win_data [NCIRC];

    generate
        for (genvar c = 0; c < NCIRC; c++) begin : g_circ
            // Eligible requests for this channel: assigned here and channel free of circuit traffic.
            always_comb begin
                for (int p = 0; p < NPORT; p++) begin
                    creq[c][p] = pk_req[p] && (pk_circ[p*CW +: CW] == CW'(c)) && !cs_valid[c];
                end
            end

            // Select the winning port's payload.
            always_comb begin
                win_data[c] = '0;
                for (int p = 0; p < NPORT; p++) begin
                    if (cgnt[c][p]) win_data[c] = pk_data[p*DW +: DW];
                end
            end

            psa_rr_arb #(.N(NPORT)) u_arb (
                .clk   (clk),
                .rst_n (rst_n),
                .req   (creq[c]),
                .gnt   (cgnt[c])
            );

            psa_chan #(.DW(DW)) u_chan (
                .clk        (clk),
                .rst_n      (rst_n),
                .cs_valid   (cs_valid[c]),
                .cs_data    (cs_data[c*DW +: DW]),
                .ps_grant   (|cgnt[c]),
                .ps_data    (win_data[c]),
                .out_valid  (out_valid[c]),
                .out_cfield (out_cfield[c]),
                .out_data   (out_data[c*DW +: DW])
            );
        end
    endgenerate

    // Merge per-channel grants into per-port grants.
    always_comb begin
        pk_gnt = '0;
        for (int c = 0; c < NCIRC; c++) pk_gnt = pk_gnt | cgnt[c];
    end

    psa_starve #(
        .NPORT   (NPORT),
        .NCIRC   (NCIRC),
        .TIMEOUT (TIMEOUT),
        .AGE_W   (AGE_W)
    ) u_starve (
        .clk           (clk),
        .rst_n         (rst_n),
        .pk_req        (pk_req),
        .pk_gnt        (pk_gnt),
        .cs_valid      (cs_valid),
        .reclaim_valid (reclaim_valid),
        .reclaim_circ  (reclaim_circ)
    );

    generate
        for (genvar p = 0; p < NPORT; p++) begin : g_port_chk
            AST_NO_STEAL_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
                pk_gnt[p] |-> !cs_valid[pk_circ[p*CW +: CW]]);     // R2
            AST_GNT_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
                pk_gnt[p] |-> pk_req[p]);                          // R5
        end
    endgenerate

endmodule

// File: tb/psa_steal_alloc_tb.sv
module psa_steal_alloc_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NPORT = 4;
    localparam int NCIRC = 4;
    localparam int DW = 16;
    localparam int TIMEOUT = 16;
    localparam int CW = 2;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [NCIRC-1:0]    cs_valid = '0;
    logic [NCIRC*DW-1:0] cs_data = '0;
    logic [NPORT-1:0]    pk_req = '0;
    logic [NPORT*CW-1:0] pk_circ = '0;
    logic [NPORT*DW-1:0] pk_data = '0;
    logic [NPORT-1:0]    pk_gnt;
    logic [NCIRC-1:0]    out_valid;
    logic [NCIRC-1:0]    out_cfield;
    logic [NCIRC*DW-1:0] out_data;
    logic                reclaim_valid;
    logic [CW-1:0]       reclaim_circ;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    psa_steal_alloc #(.NPORT(NPORT), .NCIRC(NCIRC), .DW(DW), .TIMEOUT(TIMEOUT), .AGE_W(6)) dut_i (
        .clk(clk), .rst_n(rst_n), .cs_valid(cs_valid), .cs_data(cs_data),
        .pk_req(pk_req), .pk_circ(pk_circ), .pk_data(pk_data), .pk_gnt(pk_gnt),
        .out_valid(out_valid), .out_cfield(out_cfield), .out_data(out_data),
        .reclaim_valid(reclaim_valid), .reclaim_circ(reclaim_circ)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Advance one edge and settle away from it.
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic set_port(input int p, input logic r, input int c, input logic [DW-1:0] d);
        pk_req[p] = r;
        pk_circ[p*CW +: CW] = CW'(c);
        pk_data[p*DW +: DW] = d;
    endtask

    task automatic set_cs(input int c, input logic v, input logic [DW-1:0] d);
        cs_valid[c] = v;
        cs_data[c*DW +: DW] = d;
    endtask

    task automatic t_reset();
        check("R8 out_valid", 32'(out_valid), 0);
        check("R8 pk_gnt", 32'(pk_gnt), 0);
        check("R8 reclaim", 32'(reclaim_valid), 0);
    endtask

    task automatic t_circ_pass();
        set_cs(2, 1'b1, 16'hA5C3);
        step();
        set_cs(2, 1'b0, 16'h0);
        check("R1 valid", 32'(out_valid[2]), 1);
        check("R1 cfield", 32'(out_cfield[2]), 1);
        check("R1 data", 32'(out_data[2*DW +: DW]), 32'hA5C3);
        step();
    endtask

    task automatic t_block_and_parallel();
        set_port(0, 1'b1, 1, 16'h1111);
        set_port(1, 1'b1, 0, 16'h2222);
        set_port(2, 1'b1, 3, 16'h3333);
        set_cs(1, 1'b1, 16'h0B0B);
        #1;
        check("R2 blocked by circuit flit", 32'(pk_gnt[0]), 0);
        check("R9 parallel grants", 32'(pk_gnt[2:1]), 32'b11);
        step();
        set_port(1, 1'b0, 0, 16'h0);
        set_port(2, 1'b0, 0, 16'h0);
        set_cs(1, 1'b0, 16'h0);
        #1;
        check("R2 granted once channel free", 32'(pk_gnt[0]), 1);
        step();
        set_port(0, 1'b0, 0, 16'h0);
        check("R9 port1 data on ch0", 32'(out_data[0 +: DW]), 32'h2222);
        check("R9 port2 data on ch3", 32'(out_data[3*DW +: DW]), 32'h3333);
        step();
        step();
    endtask

    task automatic t_pkt_path();
        set_port(3, 1'b1, 3, 16'hBEEF);
        #1;
        check("R3 grant", 32'(pk_gnt[3]), 1);
        step();
        set_port(3, 1'b0, 0, 16'h0);
        check("R3 not yet out", 32'(out_valid[3]), 0);
        step();
        check("R3 valid", 32'(out_valid[3]), 1);
        check("R3 cfield zero", 32'(out_cfield[3]), 0);
        check("R3 data", 32'(out_data[3*DW +: DW]), 32'hBEEF);
        step();
    endtask

    task automatic t_collide();
        set_port(0, 1'b1, 0, 16'h7070);
        step();
        set_port(0, 1'b0, 0, 16'h0);
        set_cs(0, 1'b1, 16'hC0C0);
        step();
        set_cs(0, 1'b0, 16'h0);
        check("R4 packet first cfield", 32'(out_cfield[0]), 0);
        check("R4 packet first data", 32'(out_data[0 +: DW]), 32'h7070);
        step();
        check("R4 held valid", 32'(out_valid[0]), 1);
        check("R4 held cfield", 32'(out_cfield[0]), 1);
        check("R4 held data", 32'(out_data[0 +: DW]), 32'hC0C0);
        step();
    endtask

    task automatic t_round_robin();
        set_port(0, 1'b1, 2, 16'h0);
        set_port(1, 1'b1, 2, 16'h1);
        set_port(2, 1'b1, 2, 16'h2);
        for (int k = 0; k < 4; k++) begin
            int exp_port;
            exp_port = k % 3;
            #1;
            check("R5 one grant", 32'($countones(pk_gnt)), 1);
            check("R5 rotation", 32'(pk_gnt), 32'(1 << exp_port));
            step();
        end
        pk_req = '0;
        step();
        step();
    endtask

    task automatic t_starve();
        int seen;
        set_cs(3, 1'b1, 16'h3); step(); set_cs(3, 1'b0, 16'h0);
        set_cs(0, 1'b1, 16'h4); step(); set_cs(0, 1'b0, 16'h0);
        set_cs(2, 1'b1, 16'h5); step(); set_cs(2, 1'b0, 16'h0);
        set_port(0, 1'b1, 1, 16'h9999);
        set_cs(1, 1'b1, 16'h1);
        seen = 0;
        for (int k = 0; k < 10; k++) begin
            step();
            if (reclaim_valid) seen++;
        end
        set_cs(1, 1'b0, 16'h0);
        #1;
        check("R6 grant clears wait", 32'(pk_gnt[0]), 1);
        step();
        if (reclaim_valid) seen++;
        set_cs(1, 1'b1, 16'h1);
        for (int k = 0; k < TIMEOUT; k++) begin
            step();
            if (reclaim_valid) seen++;
        end
        check("R6 no early reclaim", 32'(seen), 0);
        step();
        check("R6 reclaim fires", 32'(reclaim_valid), 1);
        check("R7 least recently used", 32'(reclaim_circ), 3);
        step();
        check("R6 one-cycle pulse", 32'(reclaim_valid), 0);
        set_cs(1, 1'b0, 16'h0);
        pk_req = '0;
        step();
        step();
    endtask

    initial begin
        #(CLK_PERIOD * 2000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        step();
        step();
        t_reset();
        rst_n = 1'b1;
        step();
        t_circ_pass();
        t_block_and_parallel();
        t_pkt_path();
        t_collide();
        t_round_robin();
        t_starve();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule